// File: doc/BRIEF.md
# Iteration Feedback Sequencer

This block runs a pipelined operator array over and over, one pass per iteration. It drives the first row of the array and collects what reaches the bottom row. When a run is launched, the first row takes its operands from a set of input registers, which stay read-only for the whole run. On every later pass, each operand lane goes through a small switch. The switch picks one of three sources for that lane: the lane's start value, the result of the pass just finished, or the result of the pass before that.

The array has a fixed depth and every row is registered. For that reason the sequencer treats a pass as finished after exactly that many clock cycles. Only at that moment does it load its bank of output registers. The bank keeps two sets of values, current and previous. On loading, it can steer any array result lane into any output register, so values move between registers as they would in a host register file.

At the end of each pass, the array raises exit flags. A flag stops the run only if its mask bit is set. When a run stops, the sequencer records three things: that the run is done, which enabled exit fired first, and whether more than one pass was executed.

Top module: `itfb_seq`

## Requirements
- R1: During the first pass after an accepted start, every operand lane k on `op_vec` equals input register lane k.
- R2: On every later pass, operand lane k is chosen by the code at `sel_cfg[2k+1:2k]`: 2'b01 selects current result lane k, 2'b10 selects previous result lane k, and 2'b00 or 2'b11 selects input lane k.
- R3: A pass lasts exactly DEPTH cycles, counted from the edge that accepts start. `out_cur` and `out_prev` change only at the edge that closes a pass, or at the edge that accepts start.
- R4: At the edge that closes a pass, `out_cur[j]` takes array result lane `out_map[2j+1:2j]` and `out_prev` takes the old `out_cur`. Both sets are cleared to zero at the edge that accepts start.
- R5: A pass ends the run only if some bit of `exit_flags & exit_mask` is set during the cycle that closes the pass. Exit flags whose mask bit is clear have no effect.
- R6: When a run ends, `done` becomes 1 and `exit_idx` holds the lowest-numbered enabled flag that is set. `multi_iter` is 1 exactly when the ending pass was not the first pass.
- R7: `busy` goes to 1 at the edge that accepts start. It stays at 1 through the edge that writes the final outputs, and it falls at the next edge.
- R8: A start pulse that arrives while `busy` is 1 is ignored.
- R9: After reset, `busy`, `done`, `multi_iter`, `exit_idx`, `out_cur` and `out_prev` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch pulse, accepted only when idle |
| in_vec | input | LANES*DW | Read-only start values, lane k at bits [k*DW +: DW] |
| sel_cfg | input | 2*LANES | Per-lane source code for later passes |
| out_map | input | LANES*MW | Result lane steered into each output register |
| exit_mask | input | NUM_EXIT | Enable for each exit flag |
| exit_flags | input | NUM_EXIT | Exit flags from the array's last row |
| res_vec | input | LANES*DW | Bottom-row results of the array |
| op_vec | output | LANES*DW | First-row operands driven into the array |
| out_cur | output | LANES*DW | Output registers, current pass |
| out_prev | output | LANES*DW | Output registers, previous pass |
| busy | output | 1 | Run in progress |
| done | output | 1 | Last run has ended |
| multi_iter | output | 1 | Last run executed more than one pass |
| exit_idx | output | EW | Index of the first enabled exit that fired |

## Verification
The bench acts as the array, with a fixed offset per result lane, and puts masked exit flags on every pass that should not end the run.

- If the design counts one cycle too many or too few per pass, its output registers move at the wrong negedge sample.
- If it ignores the mask, it stops early.
- If it mixes up the current and previous sets, or forgets to clear them on start, it feeds the second and third passes wrong operands.
- A stray start pulse in the middle of each run catches a design that relaunches while busy.
- A run that ends on its first pass exposes a wrong multi-pass flag.

// File: rtl/itfb_pkg.sv
package itfb_pkg;
   typedef enum logic [1:0] {
      SRC_START = 2'b00,
      SRC_CUR   = 2'b01,
      SRC_PREV  = 2'b10,
      SRC_ALT   = 2'b11
   } src_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'b00,
      ST_RUN   = 2'b01,
      ST_DRAIN = 2'b10
   } st_e;
endpackage

// File: rtl/itfb_timer.sv
module itfb_timer #(
   parameter int DEPTH = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic run,
   output logic last
);
   localparam int CW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   logic [CW-1:0] cnt;

   assign last = run && (cnt == CW'(DEPTH - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt <= '0;
      else if (clr)     cnt <= '0;
      else if (last)    cnt <= '0;
      else if (run)     cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/itfb_switch.sv
module itfb_switch
   import itfb_pkg::*;
#(
   parameter int DW    = 32,
   parameter int LANES = 4
) (
   input  logic               first,
   input  logic [2*LANES-1:0] sel_cfg,
   input  logic [LANES*DW-1:0] in_vec,
   input  logic [LANES*DW-1:0] cur_vec,
   input  logic [LANES*DW-1:0] prev_vec,
   output logic [LANES*DW-1:0] op_vec
);
   for (genvar k = 0; k < LANES; k++) begin : g_lane
      src_e code;
      assign code = src_e'(sel_cfg[2*k +: 2]);
      always_comb begin
         if (first) begin
            op_vec[k*DW +: DW] = in_vec[k*DW +: DW];
         end else begin
            unique case (code)
               SRC_CUR:  op_vec[k*DW +: DW] = cur_vec[k*DW +: DW];
               SRC_PREV: op_vec[k*DW +: DW] = prev_vec[k*DW +: DW];
               default:  op_vec[k*DW +: DW] = in_vec[k*DW +: DW];
            endcase
         end
      end
   end
endmodule

// File: rtl/itfb_outbank.sv
module itfb_outbank #(
   parameter int DW    = 32,
   parameter int LANES = 4,
   localparam int MW   = (LANES > 1) ? $clog2(LANES) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clr,
   input  logic                 wr,
   input  logic [LANES*MW-1:0]  out_map,
   input  logic [LANES*DW-1:0]  res_vec,
   output logic [LANES*DW-1:0]  cur_vec,
   output logic [LANES*DW-1:0]  prev_vec
);
   for (genvar j = 0; j < LANES; j++) begin : g_reg
      logic [MW-1:0] idx;
      logic [DW-1:0] pick;
      assign idx = out_map[j*MW +: MW];

      always_comb begin
         pick = res_vec[j*DW +: DW];
         for (int s = 0; s < LANES; s++) begin
            if (idx == MW'(s)) pick = res_vec[s*DW +: DW];
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cur_vec[j*DW +: DW]  <= '0;
            prev_vec[j*DW +: DW] <= '0;
         end else if (clr) begin
            cur_vec[j*DW +: DW]  <= '0;
            prev_vec[j*DW +: DW] <= '0;
         end else if (wr) begin
            cur_vec[j*DW +: DW]  <= pick;
            prev_vec[j*DW +: DW] <= cur_vec[j*DW +: DW];
         end
      end
   end
endmodule

// File: rtl/itfb_seq.sv
module itfb_seq
   import itfb_pkg::*;
#(
   parameter int DW       = 32,
   parameter int LANES    = 4,
   parameter int DEPTH    = 3,
   parameter int NUM_EXIT = 4,
   localparam int MW      = (LANES > 1) ? $clog2(LANES) : 1,
   localparam int EW      = (NUM_EXIT > 1) ? $clog2(NUM_EXIT) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic [LANES*DW-1:0]  in_vec,
   input  logic [2*LANES-1:0]   sel_cfg,
   input  logic [LANES*MW-1:0]  out_map,
   input  logic [NUM_EXIT-1:0]  exit_mask,
   input  logic [NUM_EXIT-1:0]  exit_flags,
   input  logic [LANES*DW-1:0]  res_vec,
   output logic [LANES*DW-1:0]  op_vec,
   output logic [LANES*DW-1:0]  out_cur,
   output logic [LANES*DW-1:0]  out_prev,
   output logic                 busy,
   output logic                 done,
   output logic                 multi_iter,
   output logic [EW-1:0]        exit_idx
);
   if (2*LANES > 32) begin : g_bad_lanes
      $error("itfb_seq: LANES codes must fit one 32-bit word");
   end
   if (DEPTH < 1) begin : g_bad_depth
      $error("itfb_seq: DEPTH must be at least 1");
   end
   if (NUM_EXIT < 1 || DW < 1) begin : g_bad_misc
      $error("itfb_seq: NUM_EXIT and DW must be positive");
   end

   st_e           state;
   logic          first_it;
   logic          launch;
   logic          iter_end;
   logic          stop_hit;
   logic [NUM_EXIT-1:0] live_exit;
   logic [EW-1:0] first_exit;

   assign launch    = (state == ST_IDLE) && start;
   assign live_exit = exit_flags & exit_mask;
   assign stop_hit  = iter_end && (|live_exit);
   assign busy      = (state != ST_IDLE);

   always_comb begin
      first_exit = '0;
      for (int i = NUM_EXIT - 1; i >= 0; i--) begin
         if (live_exit[i]) first_exit = EW'(i);
      end
   end

   itfb_timer #(.DEPTH(DEPTH)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (launch),
      .run   (state == ST_RUN),
      .last  (iter_end)
   );

   itfb_switch #(.DW(DW), .LANES(LANES)) u_switch (
      .first    (first_it),
      .sel_cfg  (sel_cfg),
      .in_vec   (in_vec),
      .cur_vec  (out_cur),
      .prev_vec (out_prev),
      .op_vec   (op_vec)
   );

   itfb_outbank #(.DW(DW), .LANES(LANES)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (launch),
      .wr       (iter_end),
      .out_map  (out_map),
      .res_vec  (res_vec),
      .cur_vec  (out_cur),
      .prev_vec (out_prev)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         first_it   <= 1'b1;
         done       <= 1'b0;
         multi_iter <= 1'b0;
         exit_idx   <= '0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (launch) begin
                  state      <= ST_RUN;
                  first_it   <= 1'b1;
                  done       <= 1'b0;
                  multi_iter <= 1'b0;
                  exit_idx   <= '0;
               end
            end
            ST_RUN: begin
               if (iter_end) begin
                  first_it <= 1'b0;
                  if (stop_hit) begin
                     state      <= ST_DRAIN;
                     done       <= 1'b1;
                     multi_iter <= !first_it;
                     exit_idx   <= first_exit;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/itfb_seq_chk.sv
module itfb_seq_chk #(
   parameter int DW    = 32,
   parameter int LANES = 4
) (
   input logic                clk,
   input logic                rst_n,
   input logic                launch,
   input logic                iter_end,
   input logic                first_it,
   input logic                busy,
   input logic                done,
   input logic [LANES*DW-1:0] in_vec,
   input logic [LANES*DW-1:0] op_vec,
   input logic [LANES*DW-1:0] out_cur,
   input logic [LANES*DW-1:0] out_prev
);
   AST_FIRST_PASS_INPUTS: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && first_it) |-> (op_vec == in_vec)); // R1

   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!iter_end && !launch) |=> ($stable(out_cur) && $stable(out_prev))); // R3

   AST_PREV_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
      iter_end |=> (out_prev == $past(out_cur))); // R4

   AST_DONE_AT_PASS_END: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(iter_end)); // R6

   AST_BUSY_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> (busy ##1 !busy)); // R7

   AST_NO_RELAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
      launch |-> !busy); // R8
endmodule

bind itfb_seq itfb_seq_chk #(.DW(DW), .LANES(LANES)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .launch   (launch),
   .iter_end (iter_end),
   .first_it (first_it),
   .busy     (busy),
   .done     (done),
   .in_vec   (in_vec),
   .op_vec   (op_vec),
   .out_cur  (out_cur),
   .out_prev (out_prev)
);

// File: tb/itfb_seq_bench.sv
module itfb_seq_bench;
   localparam int DW = 32, LANES = 4, DEPTH = 3, NUM_EXIT = 4;
   localparam int MW = 2, EW = 2;

   typedef struct packed {
      logic [31:0] base;
      logic [7:0]  sel;
      logic [7:0]  map;
      logic [3:0]  mask;
      logic [2:0]  exit_it;
      logic [3:0]  bits;
   } vec_t;

   localparam int NV = 5;
   localparam vec_t VEC [NV] = '{
      '{32'd100,  8'h00, 8'hE4, 4'b1111, 3'd0, 4'b0100},
      '{32'd1000, 8'h55, 8'hE4, 4'b0011, 3'd3, 4'b0010},
      '{32'd7,    8'hAA, 8'h1B, 4'b1000, 3'd2, 4'b1001},
      '{32'd50,   8'hE4, 8'h00, 4'b0110, 3'd4, 4'b0110},
      '{32'd9,    8'h9C, 8'h4E, 4'b1111, 3'd1, 4'b1000}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [LANES*DW-1:0] in_vec = '0;
   logic [2*LANES-1:0]  sel_cfg = '0;
   logic [LANES*MW-1:0] out_map = '0;
   logic [NUM_EXIT-1:0] exit_mask = '0;
   logic [NUM_EXIT-1:0] exit_flags = '0;
   logic [LANES*DW-1:0] res_vec;
   logic [LANES*DW-1:0] op_vec, out_cur, out_prev;
   logic busy, done, multi_iter;
   logic [EW-1:0] exit_idx;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   for (genvar k = 0; k < LANES; k++) begin : g_arr
      assign res_vec[k*DW +: DW] = op_vec[k*DW +: DW] + 32'(17 * (k + 1));
   end

   itfb_seq #(.DW(DW), .LANES(LANES), .DEPTH(DEPTH), .NUM_EXIT(NUM_EXIT)) u_itfb_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .in_vec(in_vec), .sel_cfg(sel_cfg),
      .out_map(out_map), .exit_mask(exit_mask), .exit_flags(exit_flags),
      .res_vec(res_vec), .op_vec(op_vec), .out_cur(out_cur), .out_prev(out_prev),
      .busy(busy), .done(done), .multi_iter(multi_iter), .exit_idx(exit_idx)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   logic [31:0] m_in [LANES];
   logic [31:0] m_cur [LANES];
   logic [31:0] m_prev [LANES];
   logic [31:0] m_op [LANES];

   task automatic run_case(input vec_t v);
      logic [31:0] res [LANES];
      logic [3:0]  en;
      int          idx;
      @(negedge clk);
      for (int k = 0; k < LANES; k++) begin
         m_in[k] = v.base + 32'(3 * k);
         in_vec[k*DW +: DW] = m_in[k];
         m_cur[k] = '0;
         m_prev[k] = '0;
      end
      sel_cfg = v.sel; out_map = v.map; exit_mask = v.mask;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check("R7 busy after start", 32'(busy), 32'd1);
      check("R4 clear on start", out_cur[31:0] | out_prev[31:0], 32'd0);
      for (int it = 0; it < 8; it++) begin
         for (int k = 0; k < LANES; k++) begin
            if (it == 0) m_op[k] = m_in[k];
            else case (v.sel[2*k +: 2])
               2'b01:   m_op[k] = m_cur[k];
               2'b10:   m_op[k] = m_prev[k];
               default: m_op[k] = m_in[k];
            endcase
            check(it == 0 ? "R1 first-pass operand" : "R2 switched operand",
                  op_vec[k*DW +: DW], m_op[k]);
         end
         exit_flags = (32'(it) == 32'(v.exit_it)) ? v.bits : ~v.mask;
         if (it > 0) start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         if (DEPTH > 2) repeat (DEPTH - 2) @(negedge clk);
         check("R3 outputs held mid-pass", out_cur[31:0], m_cur[0]);
         @(negedge clk);
         for (int k = 0; k < LANES; k++) res[k] = m_op[k] + 32'(17 * (k + 1));
         for (int k = 0; k < LANES; k++) begin
            m_prev[k] = m_cur[k];
            m_cur[k]  = res[v.map[2*k +: 2]];
            check("R4 current bank", out_cur[k*DW +: DW], m_cur[k]);
            check("R4 previous bank", out_prev[k*DW +: DW], m_prev[k]);
         end
         if (32'(it) == 32'(v.exit_it)) begin
            en = v.bits & v.mask;
            idx = 0;
            for (int b = NUM_EXIT - 1; b >= 0; b--) if (en[b]) idx = b;
            check("R6 done", 32'(done), 32'd1);
            check("R6 exit index", 32'(exit_idx), 32'(idx));
            check("R6 multi-pass flag", 32'(multi_iter), (it > 0) ? 32'd1 : 32'd0);
            check("R7 busy through final write", 32'(busy), 32'd1);
            @(negedge clk);
            check("R7 busy falls", 32'(busy), 32'd0);
            exit_flags = '0;
            break;
         end else begin
            check("R5 masked exit ignored", 32'(done), 32'd0);
            check("R8 relaunch ignored, busy", 32'(busy), 32'd1);
         end
      end
   endtask

   initial begin
      repeat (2000) @(posedge clk);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R9 busy at reset", 32'(busy), 32'd0);
      check("R9 done at reset", 32'(done), 32'd0);
      check("R9 status at reset", {30'd0, multi_iter, 1'b0} | 32'(exit_idx), 32'd0);
      check("R9 banks at reset", out_cur[31:0] | out_prev[31:0], 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R9 idle after release", 32'(busy), 32'd0);

      for (int n = 0; n < NV; n++) run_case(VEC[n]);

      // R9: reset during a run returns the block to idle
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      rst_n = 1'b0;
      @(negedge clk);
      check("R9 reset mid-run busy", 32'(busy), 32'd0);
      check("R9 reset mid-run bank", out_cur[31:0], 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule